// File: doc/BRIEF.md
# Tensor Layout Transform Address Generator

This block produces the address stream for turning a channel-major tensor of shape (channels, depth, rows, columns) into a channel-vectorized layout. The channels are grouped into sets of CVEC. Within a group, the values of every channel for one spatial position are stored next to each other. The group's whole spatial volume is stored before the next group begins. All offsets count elements, not bytes, so the same stream works for any data type.

The block has two modes, chosen by a start pulse.

- **Map mode** walks the source tensor in its natural order. For each element it reports the transformed subscripts and the transformed offset.
- **Fill mode** walks every position of the transformed tensor in ascending order. It flags positions that no source channel reaches, so a writer can store zeros there. For all other positions it reports the source offset.

A valid/ready pair paces the output. Tensor dimensions and CVEC are parameters.

Top module: `tensor_layout_agen`

## Requirements
- R1: In map mode, `log_off_o` takes the values 0 to C*D*H*W-1, one per accepted element. The column index varies fastest, then row, then depth, then channel. `dep_o`, `row_o` and `col_o` give the element's spatial subscripts.
- R2: For source channel c, `grp_o` equals c / CVEC and `lane_o` equals c mod CVEC. CVEC is a power of two.
- R3: In map mode, `xf_off_o` equals ((grp*D*H*W + (d*H + h)*W + w) * CVEC) + lane. With defaults C=3, D=1, H=2, W=2, CVEC=2, the twelve elements map to 0,2,4,6,1,3,5,7,8,10,12,14.
- R4: In fill mode, `xf_off_o` takes every value from 0 to ceil(C/CVEC)*D*H*W*CVEC-1 in ascending order. The lane varies fastest, then column, row, depth and group.
- R5: `pad_o` is 1 exactly when grp*CVEC + lane >= C, and it is always 0 in map mode. In fill mode, `log_off_o` is c*D*H*W + (d*H+h)*W + w for positions that are not padding, and 0 for padding.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, every output field holds its value. The walk advances only when valid and ready are both 1 at a clock edge.
- R7: `done_o` is 1 only while the last element of the walk is presented. After that element is accepted, `out_valid_o` is 0 in the next cycle.
- R8: A start pulse while idle samples `fill_mode_i` (0 = map mode, 1 = fill mode). The first element is presented in the cycle after the start edge.
- R9: A start pulse while a walk is in progress is ignored. The walk keeps its mode and its position.
- R10: A synchronous reset, active high, returns the block to idle with `out_valid_o` and `done_o` at 0 and all indices at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, acted on only while idle |
| fill_mode_i | input | 1 | Mode sampled at start: 0 map, 1 fill |
| out_ready_i | input | 1 | Consumer accepts the presented element |
| out_valid_o | output | 1 | An element is presented |
| grp_o | output | IDX_W | C-vector group index |
| lane_o | output | IDX_W | Channel position within its group |
| dep_o | output | IDX_W | Depth subscript |
| row_o | output | IDX_W | Row subscript |
| col_o | output | IDX_W | Column subscript |
| xf_off_o | output | OFF_W | Transformed element offset |
| log_off_o | output | OFF_W | Source element offset (0 on padding) |
| pad_o | output | 1 | Position has no source element |
| done_o | output | 1 | Presented element is the last one |

## Verification
On every cycle, the assertions compare the computed offsets against an independent running count of accepted elements: the source offset in map mode and the transformed offset in fill mode. They also check that the outputs hold during a stall, that lanes and groups stay in range, that padding never appears in map mode and that the mode survives a start pulse during a walk. Only the bench's scenarios can show that the interleaved order of transformed offsets is correct, which positions are padding and where the done flag falls. The same holds for behaviour under irregular ready patterns, a stray start pulse and a reset in the middle of a walk.

// File: rtl/tlx_pkg.sv
package tlx_pkg;
    function automatic int max_of5(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction
endpackage

// File: rtl/tlx_offset_calc.sv
module tlx_offset_calc #(
    parameter int NUM_CH = 3,
    parameter int DEPTH  = 1,
    parameter int HEIGHT = 2,
    parameter int WIDTH  = 2,
    parameter int CVEC   = 2,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 5
) (
    input  logic [IDX_W-1:0] grp_i,
    input  logic [IDX_W-1:0] lane_i,
    input  logic [IDX_W-1:0] dep_i,
    input  logic [IDX_W-1:0] row_i,
    input  logic [IDX_W-1:0] col_i,
    output logic [OFF_W-1:0] xf_off_o,
    output logic [OFF_W-1:0] log_off_o,
    output logic             pad_o
);
    localparam int LANE_LG = $clog2(CVEC);
    localparam int PLANE   = DEPTH * HEIGHT * WIDTH;
    localparam logic [OFF_W-1:0] PLANE_V = OFF_W'(PLANE);
    localparam logic [OFF_W-1:0] H_V     = OFF_W'(HEIGHT);
    localparam logic [OFF_W-1:0] W_V     = OFF_W'(WIDTH);
    localparam logic [OFF_W-1:0] CVEC_V  = OFF_W'(CVEC);
    localparam logic [OFF_W-1:0] NC_V    = OFF_W'(NUM_CH);

    generate
        if ((1 << LANE_LG) != CVEC) begin : g_bad_cvec
            $error("CVEC must be a power of two");
        end
    endgenerate

    logic [OFF_W-1:0] spatial;
    logic [OFF_W-1:0] block_idx;
    logic [OFF_W-1:0] chan;

    always_comb begin
        spatial   = (OFF_W'(dep_i) * H_V + OFF_W'(row_i)) * W_V + OFF_W'(col_i);
        block_idx = OFF_W'(grp_i) * PLANE_V + spatial;
        xf_off_o  = (block_idx << LANE_LG) | OFF_W'(lane_i);
        chan      = OFF_W'(grp_i) * CVEC_V + OFF_W'(lane_i);
        pad_o     = (chan >= NC_V);
        log_off_o = pad_o ? '0 : chan * PLANE_V + spatial;
    end
endmodule

// File: rtl/tlx_walker.sv
module tlx_walker #(
    parameter int DEPTH     = 1,
    parameter int HEIGHT    = 2,
    parameter int WIDTH     = 2,
    parameter int CVEC      = 2,
    parameter int NGROUP    = 2,
    parameter int IDX_W     = 2,
    parameter int OFF_W     = 5,
    parameter int LOG_TOTAL = 12,
    parameter int XF_TOTAL  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fill_i,
    input  logic             adv_i,
    output logic             busy_o,
    output logic             fill_o,
    output logic [IDX_W-1:0] grp_o,
    output logic [IDX_W-1:0] lane_o,
    output logic [IDX_W-1:0] dep_o,
    output logic [IDX_W-1:0] row_o,
    output logic [IDX_W-1:0] col_o,
    output logic [OFF_W-1:0] seq_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] W_LIM = IDX_W'(WIDTH - 1);
    localparam logic [IDX_W-1:0] H_LIM = IDX_W'(HEIGHT - 1);
    localparam logic [IDX_W-1:0] D_LIM = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] L_LIM = IDX_W'(CVEC - 1);
    localparam logic [IDX_W-1:0] G_LIM = IDX_W'(NGROUP - 1);
    localparam logic [OFF_W-1:0] MAP_END  = OFF_W'(LOG_TOTAL - 1);
    localparam logic [OFF_W-1:0] FILL_END = OFF_W'(XF_TOTAL - 1);

    typedef struct packed {
        logic             busy;
        logic             fill;
        logic [IDX_W-1:0] grp;
        logic [IDX_W-1:0] lane;
        logic [IDX_W-1:0] dep;
        logic [IDX_W-1:0] row;
        logic [IDX_W-1:0] col;
        logic [OFF_W-1:0] seq;
    } walk_t;

    walk_t st_d, st_q;

    // {carry_out, next_value} for one digit of the nested counter
    function automatic logic [IDX_W:0] step(logic [IDX_W-1:0] v,
                                            logic [IDX_W-1:0] lim,
                                            logic ci);
        if (!ci)      return {1'b0, v};
        if (v == lim) return {1'b1, {IDX_W{1'b0}}};
        return {1'b0, v + 1'b1};
    endfunction

    logic [IDX_W:0] s_col, s_row, s_dep, s_lane, s_grp;
    logic           last;

    assign last = st_q.fill ? (st_q.seq == FILL_END) : (st_q.seq == MAP_END);

    always_comb begin
        st_d   = st_q;
        s_col  = '0;
        s_row  = '0;
        s_dep  = '0;
        s_lane = '0;
        s_grp  = '0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d      = '0;
                st_d.busy = 1'b1;
                st_d.fill = fill_i;
            end
        end else if (adv_i) begin
            if (last) begin
                st_d = '0;
            end else begin
                st_d.seq = st_q.seq + 1'b1;
                if (st_q.fill) begin
                    // lane innermost, then column, row, depth, group
                    s_lane = step(st_q.lane, L_LIM, 1'b1);
                    s_col  = step(st_q.col,  W_LIM, s_lane[IDX_W]);
                    s_row  = step(st_q.row,  H_LIM, s_col[IDX_W]);
                    s_dep  = step(st_q.dep,  D_LIM, s_row[IDX_W]);
                    s_grp  = step(st_q.grp,  G_LIM, s_dep[IDX_W]);
                end else begin
                    // column innermost, then row, depth, channel
                    s_col  = step(st_q.col,  W_LIM, 1'b1);
                    s_row  = step(st_q.row,  H_LIM, s_col[IDX_W]);
                    s_dep  = step(st_q.dep,  D_LIM, s_row[IDX_W]);
                    s_lane = step(st_q.lane, L_LIM, s_dep[IDX_W]);
                    s_grp  = step(st_q.grp,  G_LIM, s_lane[IDX_W]);
                end
                st_d.col  = s_col[IDX_W-1:0];
                st_d.row  = s_row[IDX_W-1:0];
                st_d.dep  = s_dep[IDX_W-1:0];
                st_d.lane = s_lane[IDX_W-1:0];
                st_d.grp  = s_grp[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign fill_o = st_q.fill;
    assign grp_o  = st_q.grp;
    assign lane_o = st_q.lane;
    assign dep_o  = st_q.dep;
    assign row_o  = st_q.row;
    assign col_o  = st_q.col;
    assign seq_o  = st_q.seq;
    assign last_o = st_q.busy & last;

    // R6: an accepted, non-final element moves the count forward by exactly one
    p_seq_step_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && adv_i && !last |=> st_q.seq == OFF_W'($past(st_q.seq) + 1'b1));

    // R6: without a handshake the walk does not move
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && !adv_i |=> $stable(st_q));

    // R9: a start pulse mid-walk leaves the mode untouched
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && start_i && !(adv_i && last) |=> st_q.busy && st_q.fill == $past(st_q.fill));
endmodule

// File: rtl/tensor_layout_agen.sv
module tensor_layout_agen #(
    parameter int NUM_CH = 3,
    parameter int DEPTH  = 1,
    parameter int HEIGHT = 2,
    parameter int WIDTH  = 2,
    parameter int CVEC   = 2,
    localparam int NGROUP    = (NUM_CH + CVEC - 1) / CVEC,
    localparam int PLANE     = DEPTH * HEIGHT * WIDTH,
    localparam int LOG_TOTAL = NUM_CH * PLANE,
    localparam int XF_TOTAL  = NGROUP * PLANE * CVEC,
    localparam int MAXD      = tlx_pkg::max_of5(DEPTH, HEIGHT, WIDTH, CVEC, NGROUP),
    localparam int IDX_W     = $clog2(MAXD + 1),
    localparam int OFF_W     = $clog2(XF_TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fill_mode_i,
    input  logic             out_ready_i,
    output logic             out_valid_o,
    output logic [IDX_W-1:0] grp_o,
    output logic [IDX_W-1:0] lane_o,
    output logic [IDX_W-1:0] dep_o,
    output logic [IDX_W-1:0] row_o,
    output logic [IDX_W-1:0] col_o,
    output logic [OFF_W-1:0] xf_off_o,
    output logic [OFF_W-1:0] log_off_o,
    output logic             pad_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] CVEC_V   = IDX_W'(CVEC);
    localparam logic [IDX_W-1:0] NGROUP_V = IDX_W'(NGROUP);

    logic             busy, fill, last;
    logic [OFF_W-1:0] seq;

    tlx_walker #(
        .DEPTH(DEPTH), .HEIGHT(HEIGHT), .WIDTH(WIDTH), .CVEC(CVEC),
        .NGROUP(NGROUP), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .LOG_TOTAL(LOG_TOTAL), .XF_TOTAL(XF_TOTAL)
    ) u_walk (
        .clk(clk), .rst(rst), .start_i(start_i), .fill_i(fill_mode_i),
        .adv_i(out_valid_o & out_ready_i),
        .busy_o(busy), .fill_o(fill),
        .grp_o(grp_o), .lane_o(lane_o), .dep_o(dep_o), .row_o(row_o), .col_o(col_o),
        .seq_o(seq), .last_o(last)
    );

    tlx_offset_calc #(
        .NUM_CH(NUM_CH), .DEPTH(DEPTH), .HEIGHT(HEIGHT), .WIDTH(WIDTH),
        .CVEC(CVEC), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_calc (
        .grp_i(grp_o), .lane_i(lane_o), .dep_i(dep_o), .row_i(row_o), .col_i(col_o),
        .xf_off_o(xf_off_o), .log_off_o(log_off_o), .pad_o(pad_o)
    );

    assign out_valid_o = busy;
    assign done_o      = last;

    // R1: map-mode source offset agrees with the count of accepted elements
    p_map_logseq_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !fill |-> log_off_o == seq);

    // R4: fill-mode transformed offset agrees with the count of accepted elements
    p_fill_xfseq_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && fill |-> xf_off_o == seq);

    // R2: lane and group stay inside their ranges
    p_lane_range_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (lane_o < CVEC_V) && (grp_o < NGROUP_V));

    // R5: a source walk never lands on padding; padding carries a zero source offset
    p_map_nopad_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !fill |-> !pad_o);
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && pad_o |-> log_off_o == '0);

    // R6: outputs hold while the consumer stalls
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(xf_off_o) && $stable(log_off_o) && $stable(pad_o));

    // R7: accepting the final element ends the walk
    p_done_end_r7: assert property (@(posedge clk) disable iff (rst)
        done_o && out_ready_i |=> !out_valid_o);
endmodule

// File: tb/tb_tensor_layout_agen.sv
`timescale 1ns/1ps
module tb_tensor_layout_agen;
    localparam int NC = 3, DP = 1, HT = 2, WD = 2, CV = 2;
    localparam int PL = DP * HT * WD;
    localparam int NG = (NC + CV - 1) / CV;
    localparam int LOG_N = NC * PL;
    localparam int XF_N  = NG * PL * CV;
    localparam int IDX_W = 2, OFF_W = 5;

    // expected transformed offsets for source offsets 0..11 (R3)
    localparam int MAP_XF [LOG_N] = '{0, 2, 4, 6, 1, 3, 5, 7, 8, 10, 12, 14};

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, fill_mode_i = 1'b0, out_ready_i = 1'b0;
    logic out_valid_o, pad_o, done_o;
    logic [IDX_W-1:0] grp_o, lane_o, dep_o, row_o, col_o;
    logic [OFF_W-1:0] xf_off_o, log_off_o;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    tensor_layout_agen #(.NUM_CH(NC), .DEPTH(DP), .HEIGHT(HT), .WIDTH(WD), .CVEC(CV)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .fill_mode_i(fill_mode_i),
        .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
        .grp_o(grp_o), .lane_o(lane_o), .dep_o(dep_o), .row_o(row_o), .col_o(col_o),
        .xf_off_o(xf_off_o), .log_off_o(log_off_o), .pad_o(pad_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_map(input int idx);
        int c, sp;
        c  = idx / PL;
        sp = idx % PL;
        check(int'(xf_off_o) == MAP_XF[idx], "R3 map xf offset", int'(xf_off_o), MAP_XF[idx]);
        check(int'(log_off_o) == idx, "R1 map source offset", int'(log_off_o), idx);
        check(int'(col_o) == sp % WD && int'(row_o) == (sp / WD) % HT && int'(dep_o) == sp / (WD * HT),
              "R1 spatial subscripts", int'({dep_o, row_o, col_o}), sp);
        check(int'(grp_o) == c / CV, "R2 group", int'(grp_o), c / CV);
        check(int'(lane_o) == c % CV, "R2 lane", int'(lane_o), c % CV);
        check(pad_o == 1'b0, "R5 map pad", int'(pad_o), 0);
        check(done_o == (idx == LOG_N - 1), "R7 map done", int'(done_o), int'(idx == LOG_N - 1));
    endtask

    task automatic check_fill(input int idx);
        int ln, sp, g, ch, exp_log;
        bit pd;
        ln = idx % CV;
        sp = (idx / CV) % PL;
        g  = idx / (CV * PL);
        ch = g * CV + ln;
        pd = (ch >= NC);
        exp_log = pd ? 0 : ch * PL + sp;
        check(int'(xf_off_o) == idx, "R4 fill xf offset", int'(xf_off_o), idx);
        check(int'(lane_o) == ln && int'(grp_o) == g, "R4 fill lane/group", int'({grp_o, lane_o}), g * 4 + ln);
        check(pad_o == pd, "R5 fill pad", int'(pad_o), int'(pd));
        check(int'(log_off_o) == exp_log, "R5 fill source offset", int'(log_off_o), exp_log);
        check(done_o == (idx == XF_N - 1), "R7 fill done", int'(done_o), int'(idx == XF_N - 1));
    endtask

    // pat 0: always ready; 1: one stall in three; 2: alternate
    task automatic run(input bit fill, input int pat, input bit inject);
        int total, idx, cyc;
        bit held, injected;
        logic [OFF_W-1:0] h_xf, h_log;
        total = fill ? XF_N : LOG_N;
        idx = 0; cyc = 0; held = 0; injected = 0;
        h_xf = '0; h_log = '0;
        start_i = 1'b1;
        fill_mode_i = fill;
        @(negedge clk);
        start_i = 1'b0;
        check(out_valid_o == 1'b1, "R8 first element after start", int'(out_valid_o), 1);
        while (idx < total) begin
            case (pat)
                1:       out_ready_i = (cyc % 3 != 1);
                2:       out_ready_i = (cyc % 2 == 0);
                default: out_ready_i = 1'b1;
            endcase
            cyc++;
            if (held) begin
                check(xf_off_o == h_xf && log_off_o == h_log, "R6 hold during stall",
                      int'(xf_off_o), int'(h_xf));
                held = 0;
            end
            start_i = 1'b0;
            if (inject && idx == 3 && !injected) begin
                start_i = 1'b1;
                fill_mode_i = !fill;
                injected = 1;
            end
            if (!out_valid_o) begin
                check(1'b0, "R6 valid dropped mid-walk", 0, 1);
                idx = total;
            end else if (out_ready_i) begin
                if (fill) check_fill(idx);
                else      check_map(idx);
                idx++;
            end else begin
                held = 1;
                h_xf = xf_off_o;
                h_log = log_off_o;
            end
            if (idx < total) @(negedge clk);
        end
        @(negedge clk);
        start_i = 1'b0;
        out_ready_i = 1'b0;
        check(out_valid_o == 1'b0, "R7 idle after last accept", int'(out_valid_o), 0);
        check(done_o == 1'b0, "R7 done cleared", int'(done_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0 && done_o == 1'b0, "R10 reset idle", int'(out_valid_o), 0);
        check(grp_o == '0 && lane_o == '0 && col_o == '0 && row_o == '0, "R10 reset indices",
              int'({grp_o, lane_o, row_o, col_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid_o == 1'b0, "R8 idle without start", int'(out_valid_o), 0);

        run(1'b0, 0, 1'b0);   // map, free flow
        run(1'b0, 1, 1'b0);   // map, with stalls
        run(1'b1, 0, 1'b0);   // fill, free flow
        run(1'b1, 2, 1'b0);   // fill, alternating ready
        run(1'b0, 2, 1'b1);   // R9: stray start into a map walk
        run(1'b1, 1, 1'b1);   // R9: stray start into a fill walk

        // R10: reset in the middle of a walk
        start_i = 1'b1; fill_mode_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; out_ready_i = 1'b1;
        repeat (5) @(negedge clk);
        check(out_valid_o == 1'b1, "R10 walk running before reset", int'(out_valid_o), 1);
        rst = 1'b1; out_ready_i = 1'b0;
        @(negedge clk);
        check(out_valid_o == 1'b0 && done_o == 1'b0, "R10 reset mid-walk", int'(out_valid_o), 0);
        check(xf_off_o == '0 && lane_o == '0, "R10 reset clears position", int'(xf_off_o), 0);
        rst = 1'b0;
        @(negedge clk);
        run(1'b0, 0, 1'b0);   // restarts from offset 0 after reset

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule